// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits on the receive path after preamble removal and ahead of the receive FIFO. It watches each incoming frame byte by byte and decides whether the frame should be kept. The decision rests on the destination address (the first six bytes) and on the frame check sequence carried in the last four bytes. Every in-frame byte is passed on one cycle later, FCS bytes included. The FIFO is expected to hold the frame provisionally and then commit or drop it when the verdict arrives.

Configuration inputs select promiscuous operation, acceptance of group (multicast) addresses, and rejection of frames whose FCS is wrong. A 48-bit station address is matched against the destination for unicast delivery. The all-ones broadcast address is always accepted. Frames that are too short to hold a header are always dropped. The verdict is one strobe, issued in the cycle after the end-of-frame byte, together with a keep or drop bit.

Top module: `rx_frame_filter`

## Requirements
- R1: When cfgPromisc is 1, a frame of at least 14 bytes whose FCS is acceptable is kept whatever its destination address.
- R2: When cfgMcast is 1, a frame whose first byte has bit 0 set is kept. When cfgMcast is 0 and cfgPromisc is 0, such a frame is dropped unless it is broadcast.
- R3: With both modes off, a frame is kept only if its six destination bytes are all 0xFF, or if they equal the station address. The first received byte is compared with stationAddr[47:40] and the sixth with stationAddr[7:0]. A difference in any one byte drops the frame.
- R4: The FCS is the complement of the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, each byte taken LSB first) over all bytes before it, sent lowest byte first. When cfgRejectBadFcs is 1, a frame with a wrong FCS is dropped even if its address passes. When it is 0, the FCS has no effect on the verdict. A correct frame leaves 0xDEBB20E3 in the reflected CRC register, which is the same residue as 0xC704DD7B in non-reflected form.
- R5: Every byte of a frame, from the start byte to the end byte and including the four FCS bytes, appears on outData with outValid one cycle after it is presented. outSof and outEof mark the first and last bytes.
- R6: verdictValid pulses for exactly one cycle per frame, in the cycle after the end-of-frame byte, together with outEof.
- R7: A frame of fewer than 14 bytes, counting the start and end bytes, is dropped in every mode. A frame of exactly 14 bytes is eligible.
- R8: Bytes presented while no frame is open and without inSof are ignored: they are not forwarded and they produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| cfgPromisc | input | 1 | Keep frames for any destination |
| cfgMcast | input | 1 | Keep group-addressed frames |
| cfgRejectBadFcs | input | 1 | Drop frames with a wrong FCS |
| stationAddr | input | 48 | Own unicast address, first byte in bits 47:40 |
| outValid | output | 1 | Forwarded byte present |
| outData | output | 8 | Forwarded byte |
| outSof | output | 1 | Forwarded byte starts a frame |
| outEof | output | 1 | Forwarded byte ends a frame |
| verdictValid | output | 1 | Verdict strobe, once per frame |
| verdictKeep | output | 1 | 1 commits the frame, 0 discards it |

## Verification
The hardest cases are the ones where only a single bit separates keep from drop. One is a destination that differs from the station address in the sixth byte alone. Another is a frame whose length sits exactly at the 13/14-byte boundary. A third is a valid address paired with an FCS that is off by one bit. The bench builds every frame itself and appends an FCS computed by its own bit-serial CRC. It then corrupts exactly one byte, or trims exactly one byte, to reach each of these edges. It also drives stray bytes outside any frame to show that they leave no trace.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  localparam int OCTET_W = 8;
  localparam int IDX_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic addrByte;
    logic [IDX_W-1:0] addrIdx;
    logic fwdByte;
  } dpCtrl_t;
endpackage

// File: rtl/rx_filter_ctrl.sv
module rx_filter_ctrl
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN = 14,
  parameter int CNT_W = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inSof,
  input  logic inEof,
  input  logic cfgPromisc,
  input  logic cfgMcast,
  input  logic cfgRejectBadFcs,
  input  logic addrHit,
  input  logic addrBcast,
  input  logic addrMcast,
  input  logic crcGood,
  output dpCtrl_t ctl,
  output logic verdictValid,
  output logic verdictKeep
);
  localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(MIN_LEN - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BYTES);

  logic inFrame;
  logic [CNT_W-1:0] byteCnt;
  logic startByte, frameByte, endByte, lenOk, addrPass, crcPass;

  always_comb begin
    startByte = inValid && inSof;
    frameByte = inValid && !inSof && inFrame;
    endByte   = (startByte || frameByte) && inEof;
    lenOk     = frameByte && (byteCnt >= LEN_LAST);
    addrPass  = cfgPromisc || addrBcast || addrHit || (cfgMcast && addrMcast);
    crcPass   = !cfgRejectBadFcs || crcGood;
    ctl.startFrame = startByte;
    ctl.addrByte   = frameByte && (byteCnt < ADDR_END);
    ctl.addrIdx    = byteCnt[IDX_W-1:0];
    ctl.fwdByte    = startByte || frameByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      byteCnt      <= '0;
      verdictValid <= 1'b0;
      verdictKeep  <= 1'b0;
    end else begin
      if (startByte) begin
        inFrame <= !inEof;
        byteCnt <= CNT_W'(1);
      end else if (frameByte) begin
        if (inEof) inFrame <= 1'b0;
        if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
      end
      verdictValid <= endByte;
      verdictKeep  <= endByte && lenOk && addrPass && crcPass;
    end
  end

  // R6
  verdict_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $past(inValid && inEof));
  // R7
  short_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && inEof) |=> !verdictKeep);
  // R4
  bad_fcs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endByte && cfgRejectBadFcs && !crcGood) |=> !verdictKeep);
  // R1
  promisc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endByte && lenOk && cfgPromisc && !cfgRejectBadFcs) |=> verdictKeep);
endmodule

// File: rtl/rx_filter_dp.sv
module rx_filter_dp
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter logic [31:0] CRC_RESIDUE = 32'hDEBB20E3
) (
  input  logic clk,
  input  logic rstN,
  input  dpCtrl_t ctl,
  input  logic [OCTET_W-1:0] inData,
  input  logic inEof,
  input  logic [ADDR_BYTES*OCTET_W-1:0] stationAddr,
  output logic addrHit,
  output logic addrBcast,
  output logic addrMcast,
  output logic crcGood,
  output logic outValid,
  output logic [OCTET_W-1:0] outData,
  output logic outSof,
  output logic outEof
);
  logic [OCTET_W-1:0] stationOct [ADDR_BYTES];
  logic [OCTET_W-1:0] selOct;
  logic [31:0] crcReg, crcSeed, crcNext;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_oct
    assign stationOct[k] = stationAddr[(ADDR_BYTES-1-k)*OCTET_W +: OCTET_W];
  end

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    selOct = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (ctl.addrIdx == IDX_W'(k)) selOct = stationOct[k];
    crcSeed = ctl.startFrame ? 32'hFFFFFFFF : crcReg;
    crcNext = crcStep(crcSeed, inData);
    crcGood = (crcNext == CRC_RESIDUE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '1;
      addrHit   <= 1'b0;
      addrBcast <= 1'b0;
      addrMcast <= 1'b0;
      outValid  <= 1'b0;
      outData   <= '0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
    end else begin
      if (ctl.fwdByte) crcReg <= crcNext;
      if (ctl.startFrame) begin
        addrHit   <= (inData == stationOct[0]);
        addrBcast <= (inData == 8'hFF);
        addrMcast <= inData[0];
      end else if (ctl.addrByte) begin
        addrHit   <= addrHit && (inData == selOct);
        addrBcast <= addrBcast && (inData == 8'hFF);
      end
      outValid <= ctl.fwdByte;
      if (ctl.fwdByte) outData <= inData;
      outSof <= ctl.startFrame;
      outEof <= ctl.fwdByte && inEof;
    end
  end

  // R5
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fwdByte |=> (outValid && outData == $past(inData)));
  // R2
  group_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startFrame |=> (addrMcast == $past(inData[0])));
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN = 14,
  parameter int CNT_W = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [7:0] inData,
  input  logic inSof,
  input  logic inEof,
  input  logic cfgPromisc,
  input  logic cfgMcast,
  input  logic cfgRejectBadFcs,
  input  logic [47:0] stationAddr,
  output logic outValid,
  output logic [7:0] outData,
  output logic outSof,
  output logic outEof,
  output logic verdictValid,
  output logic verdictKeep
);
  dpCtrl_t ctl;
  logic addrHit, addrBcast, addrMcast, crcGood;

  rx_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .cfgPromisc(cfgPromisc), .cfgMcast(cfgMcast), .cfgRejectBadFcs(cfgRejectBadFcs),
    .addrHit(addrHit), .addrBcast(addrBcast), .addrMcast(addrMcast), .crcGood(crcGood),
    .ctl(ctl), .verdictValid(verdictValid), .verdictKeep(verdictKeep));

  rx_filter_dp #(.ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inEof(inEof),
    .stationAddr(stationAddr), .addrHit(addrHit), .addrBcast(addrBcast),
    .addrMcast(addrMcast), .crcGood(crcGood), .outValid(outValid),
    .outData(outData), .outSof(outSof), .outEof(outEof));

  // R6
  verdict_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> (outValid && outEof));
endmodule

// File: tb/tb_rx_frame_filter.sv
`timescale 1ns/1ps
module tb_rx_frame_filter;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inSof = 0, inEof = 0;
  logic [7:0] inData = 0;
  logic cfgPromisc = 0, cfgMcast = 0, cfgRejectBadFcs = 1;
  logic [47:0] stationAddr = 48'h02_11_22_33_44_55;
  logic outValid, outSof, outEof, verdictValid, verdictKeep;
  logic [7:0] outData;

  int checks = 0, fails = 0;
  logic [7:0] frm [0:127];
  logic [7:0] cap [0:127];
  int capN = 0, vCnt = 0, sofSeen = 0, eofSeen = 0;
  logic vKeep = 0;

  always #2.5 clk = ~clk;

  rx_frame_filter dut (.*);

  always @(negedge clk) begin
    if (outValid && capN < 128) begin
      cap[capN] = outData;
      if (outSof && capN == 0) sofSeen++;
      if (outEof) eofSeen++;
      capN++;
    end
    if (verdictValid) begin
      vCnt++;
      vKeep = verdictKeep;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bitCrc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ frm[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic build(input logic [47:0] dst, input int n);
    logic [31:0] f;
    for (int i = 0; i < n - 4; i++) begin
      if (i < 6) frm[i] = dst[(5-i)*8 +: 8];
      else if (i < 12) frm[i] = 8'hA0 + 8'(i);
      else frm[i] = 8'(i * 7 + 3);
    end
    f = bitCrc(n - 4);
    for (int i = 0; i < 4; i++) frm[n-4+i] = f[i*8 +: 8];
  endtask

  task automatic send(input int n);
    capN = 0; vCnt = 0; vKeep = 0; sofSeen = 0; eofSeen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1; inData = frm[i]; inSof = (i == 0); inEof = (i == n - 1);
    end
    @(negedge clk);
    inValid = 0; inSof = 0; inEof = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(input int n, input bit expKeep, input string tag);
    int bad = 0;
    send(n);
    check(vCnt == 1, {tag, " R6 verdict count"}, vCnt, 1);
    check(vKeep == expKeep, {tag, " verdict"}, vKeep, expKeep);
    for (int i = 0; i < n; i++) if (cap[i] != frm[i]) bad++;
    check(capN == n && bad == 0, {tag, " R5 stream"}, capN * 1000 + bad, n * 1000);
  endtask

  task automatic t_reset();
    check(!outValid && !verdictValid, "R6 reset outputs idle", {outValid, verdictValid}, 0);
  endtask

  task automatic t_unicast();
    cfgPromisc = 0; cfgMcast = 0; cfgRejectBadFcs = 1;
    build(48'h02_11_22_33_44_55, 64); runFrame(64, 1, "R3 unicast match");
    check(sofSeen == 1 && eofSeen == 1, "R5 markers", sofSeen * 10 + eofSeen, 11);
    build(48'h02_11_22_33_44_54, 64); runFrame(64, 0, "R3 last byte mismatch");
    build(48'h03_11_22_33_44_55, 64); runFrame(64, 0, "R3 first byte mismatch");
    build(48'hFF_FF_FF_FF_FF_FF, 60); runFrame(60, 1, "R3 broadcast");
    build(48'hFF_FF_FF_FF_FF_FE, 60); runFrame(60, 0, "R3 near broadcast");
  endtask

  task automatic t_mcast();
    cfgPromisc = 0; cfgRejectBadFcs = 1;
    cfgMcast = 0; build(48'h01_00_5E_00_00_01, 64); runFrame(64, 0, "R2 mcast off");
    cfgMcast = 1; build(48'h01_00_5E_00_00_01, 64); runFrame(64, 1, "R2 mcast on");
    cfgMcast = 1; build(48'h06_00_5E_00_00_01, 64); runFrame(64, 0, "R2 unicast other");
    cfgMcast = 0;
  endtask

  task automatic t_promisc();
    cfgPromisc = 1; cfgRejectBadFcs = 1;
    build(48'h0A_0B_0C_0D_0E_0F, 70); runFrame(70, 1, "R1 promisc any dest");
    cfgPromisc = 0;
  endtask

  task automatic t_fcs();
    cfgPromisc = 0; cfgMcast = 0;
    cfgRejectBadFcs = 1; build(48'h02_11_22_33_44_55, 64); frm[63] ^= 8'h01;
    runFrame(64, 0, "R4 bad fcs rejected");
    cfgRejectBadFcs = 0; build(48'h02_11_22_33_44_55, 64); frm[63] ^= 8'h01;
    runFrame(64, 1, "R4 bad fcs ignored");
    cfgRejectBadFcs = 1; build(48'h02_11_22_33_44_55, 64); frm[20] ^= 8'h80;
    runFrame(64, 0, "R4 payload corruption");
  endtask

  task automatic t_short();
    cfgPromisc = 1; cfgRejectBadFcs = 1;
    build(48'h02_11_22_33_44_55, 13); runFrame(13, 0, "R7 13 bytes");
    build(48'h02_11_22_33_44_55, 14); runFrame(14, 1, "R7 14 bytes");
    frm[0] = 8'hFF; runFrame(1, 0, "R7 single byte");
    cfgPromisc = 0;
  endtask

  task automatic t_stray();
    capN = 0; vCnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1; inData = 8'(8'h30 + i); inSof = 0; inEof = (i == 3);
    end
    @(negedge clk);
    inValid = 0; inEof = 0;
    repeat (3) @(negedge clk);
    check(capN == 0 && vCnt == 0, "R8 stray bytes ignored", capN * 10 + vCnt, 0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_mcast();
    t_promisc();
    t_fcs();
    t_short();
    t_stray();
    cfgRejectBadFcs = 1;
    build(48'h02_11_22_33_44_55, 64); runFrame(64, 1, "R3 after stray");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule